// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial flash command at a time as an SPI master in clock mode 3, half duplex. Software loads an address word and a data word through a small register port, then writes a command word. That write starts a frame. The frame shifts out an opcode byte, then an optional address of one to four bytes, then optional zero-valued dummy bytes, then up to four data bytes. The data bytes are either taken from the data word and sent, or received from the flash and stored in the data word.

A keep-select flag in the command word leaves the chip select asserted after the frame ends. While the select is held, each further command runs only its data phase, so a long read or write is built as a chain of four-byte commands. A command with the flag cleared and a data count of zero closes the chain and releases the select. A status word reports a pending bit and a sticky error bit. The error bit records a command written while another command was still running.

Top module: `sfc_seq`

## Requirements
- R1: A write to the command register (select 2) while idle starts a command. Command word fields: opcode bits 7:0, direction bit 8 (1 = send data to flash), data count bits 11:9, keep-select bit 15, dummy count bits 19:16, address count bits 22:20, select index bits 26:24. Reading select 2 returns the last accepted command word.
- R2: An unheld command sends the opcode first, then the low N bytes of the address register (select 0), most significant of those bytes first, with N = address count and values above 4 treated as 4. It then sends D zero bytes, where D is the dummy count (0 to 15), and then the data phase. Bits within each byte go out most significant bit first.
- R3: The data count is clamped to 4. Data byte j on the wire maps to bits 8j+7:8j of the data register (select 1). A write command sends those bytes. A read command drives zeros on MOSI, stores each received byte into its slot, and leaves the slots beyond the count unchanged.
- R4: The serial clock idles high. MOSI changes only while the clock is low. The flash samples MISO and MOSI on the rising edge.
- R5: Status register (select 3) bit 22 reads 1 from the cycle after a command is accepted until its frame ends. While it is 1, a chip select is asserted.
- R6: A command write while bit 22 is set sets status bit 29 and is otherwise ignored. Address and data writes while bit 22 is set are ignored.
- R7: Writing a 1 to status bit 29 clears it. No other status write changes the status register.
- R8: With keep-select set, the select stays asserted after the frame. The next command then skips the opcode, address and dummy phases, runs only its data phase, and keeps the held select index.
- R9: While a select is held, a command with keep-select clear and data count 0 releases the select without producing any clock edge.
- R10: The 3-bit select index drives one active-low select line. At most one line is low at any time, and all lines are high while no frame is running and no select is held.
- R11: After reset, the status register reads 0, all select lines are high and the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 address, 1 data, 2 command, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_sel_i |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| cs_no | output | NCS | Active-low select lines |

## Verification
The bench builds the block with a serial clock half period of two system cycles and eight select lines. The short half period keeps even a 20-byte frame with fifteen dummy bytes cheap to run. Eight lines let every value of the 3-bit index reach a real line, index 7 included, so the decode and the one-hot rule are checked across the whole field. A flash model on the wire returns a known byte pattern that continues across a held chain, so the read data of chained commands can be predicted from the byte position alone.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned ST_PEND_BIT = 22;
  localparam int unsigned ST_ERR_BIT  = 29;
  localparam int unsigned MAX_BYTES   = 4;

  typedef enum logic [1:0] {SEL_ADDR = 2'd0, SEL_DATA = 2'd1, SEL_CMD = 2'd2, SEL_STAT = 2'd3} reg_sel_e;
  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUM, PH_DATA, PH_FIN} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} seq_st_e;

  typedef struct packed {
    logic [2:0] csi;
    logic [2:0] alen;
    logic [3:0] dum;
    logic       keep;
    logic [2:0] dlen;
    logic       dir;
    logic [7:0] opc;
  } cmd_t;

  function automatic logic [2:0] clamp4(input logic [2:0] v);
    return (v > 3'(MAX_BYTES)) ? 3'(MAX_BYTES) : v;
  endfunction

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.opc  = w[7:0];
    c.dir  = w[8];
    c.dlen = clamp4(w[11:9]);
    c.keep = w[15];
    c.dum  = w[19:16];
    c.alen = clamp4(w[22:20]);
    c.csi  = w[26:24];
    return c;
  endfunction

  function automatic logic [3:0] phase_len(input phase_e p, input cmd_t c);
    case (p)
      PH_OPC:  return 4'd1;
      PH_ADDR: return {1'b0, c.alen};
      PH_DUM:  return c.dum;
      PH_DATA: return {1'b0, c.dlen};
      default: return 4'd0;
    endcase
  endfunction

  function automatic phase_e next_phase(input phase_e p, input cmd_t c);
    phase_e n = PH_FIN;
    if (p == PH_OPC && c.alen != 3'd0) n = PH_ADDR;
    else if ((p == PH_OPC || p == PH_ADDR) && c.dum != 4'd0) n = PH_DUM;
    else if (p != PH_DATA && c.dlen != 3'd0) n = PH_DATA;
    return n;
  endfunction
endpackage

// File: rtl/sfc_cs_dec.sv
module sfc_cs_dec #(
  parameter int unsigned NCS = 8
) (
  input  logic           act_i,
  input  logic [2:0]     idx_i,
  output logic [NCS-1:0] cs_no
);
  for (genvar g = 0; g < NCS; g++) begin : g_line
    assign cs_no[g] = !(act_i && (idx_i == 3'(g)));
  end
endmodule

// File: rtl/sfc_byte_shift.sv
// One byte, MSB first, mode 3: drive on falling edge, sample on rising edge.
module sfc_byte_shift #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rx_o   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sck_o  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          sck_o  <= 1'b0;
          sh_q   <= tx_i;
          bit_q  <= '0;
          cnt_q  <= '0;
        end
      end else if (cnt_q != LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (!sck_o) begin
          sck_o <= 1'b1;
          rx_o  <= {rx_o[6:0], miso_i};
        end else if (bit_q == 3'd7) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          sck_o <= 1'b0;
          sh_q  <= {sh_q[6:0], 1'b0};
          bit_q <= bit_q + 3'd1;
        end
      end
    end
  end

  assign mosi_o = sh_q[7];
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq import sfc_pkg::*; #(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned NCS      = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [1:0]     reg_sel_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic           sck_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_no
);
  logic [31:0] addr_q, data_q, cmd_q;
  cmd_t        cur_q, new_cmd;
  seq_st_e     st_q;
  phase_e      ph_q, ph_nx;
  logic [3:0]  idx_q;
  logic        err_q, held_q, pend_q;
  logic        sh_start, sh_done;
  logic [7:0]  sh_tx, sh_rx;
  logic [1:0]  a_pos;
  logic        cmd_wr, last_byte;

  assign new_cmd   = unpack_cmd(reg_wdata_i);
  assign cmd_wr    = reg_we_i && (reg_sel_i == SEL_CMD);
  assign pend_q    = (st_q != ST_IDLE);
  assign sh_start  = (st_q == ST_SEND);
  assign a_pos     = cur_q.alen[1:0] - 2'd1 - idx_q[1:0];
  assign last_byte = (idx_q + 4'd1) == phase_len(ph_q, cur_q);
  assign ph_nx     = next_phase(ph_q, cur_q);

  always_comb begin
    sh_tx = 8'h00;
    case (ph_q)
      PH_OPC:  sh_tx = cur_q.opc;
      PH_ADDR: sh_tx = addr_q[{a_pos, 3'b000} +: 8];
      PH_DATA: sh_tx = cur_q.dir ? data_q[{idx_q[1:0], 3'b000} +: 8] : 8'h00;
      default: sh_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      cmd_q  <= '0;
      cur_q  <= '0;
      st_q   <= ST_IDLE;
      ph_q   <= PH_OPC;
      idx_q  <= '0;
      err_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      if (reg_we_i && reg_sel_i == SEL_STAT && reg_wdata_i[ST_ERR_BIT]) err_q <= 1'b0;
      if (cmd_wr && pend_q) err_q <= 1'b1;
      if (reg_we_i && !pend_q) begin
        if (reg_sel_i == SEL_ADDR) addr_q <= reg_wdata_i;
        if (reg_sel_i == SEL_DATA) data_q <= reg_wdata_i;
      end
      case (st_q)
        ST_IDLE: if (cmd_wr) begin
          cmd_q <= reg_wdata_i;
          cur_q <= new_cmd;
          idx_q <= '0;
          if (held_q) begin
            cur_q.csi <= cur_q.csi;  // held line keeps its index
            if (new_cmd.dlen != 3'd0) begin
              ph_q <= PH_DATA;
              st_q <= ST_SEND;
            end else begin
              held_q <= new_cmd.keep;
            end
          end else begin
            ph_q <= PH_OPC;
            st_q <= ST_SEND;
          end
        end
        ST_SEND: st_q <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          if (ph_q == PH_DATA && !cur_q.dir) data_q[{idx_q[1:0], 3'b000} +: 8] <= sh_rx;
          if (last_byte) begin
            idx_q <= '0;
            if (ph_nx == PH_FIN) begin
              st_q   <= ST_IDLE;
              held_q <= cur_q.keep;
            end else begin
              ph_q <= ph_nx;
              st_q <= ST_SEND;
            end
          end else begin
            idx_q <= idx_q + 4'd1;
            st_q  <= ST_SEND;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_i)
      SEL_ADDR: reg_rdata_o = addr_q;
      SEL_DATA: reg_rdata_o = data_q;
      SEL_CMD:  reg_rdata_o = cmd_q;
      default:  reg_rdata_o = {2'b00, err_q, 6'b0, pend_q, 22'b0};
    endcase
  end

  sfc_byte_shift #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sh_start),
    .tx_i   (sh_tx),
    .miso_i (miso_i),
    .done_o (sh_done),
    .rx_o   (sh_rx),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  sfc_cs_dec #(.NCS(NCS)) u_csdec (
    .act_i(pend_q || held_q),
    .idx_i(cur_q.csi),
    .cs_no(cs_no)
  );
endmodule

// File: rtl/sfc_seq_chk.sv
module sfc_seq_chk import sfc_pkg::*; #(
  parameter int unsigned NCS = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_we_i,
  input logic [1:0]     reg_sel_i,
  input logic [31:0]    reg_wdata_i,
  input logic [NCS-1:0] cs_ni,
  input logic           sck_i,
  input logic           mosi_i,
  input logic           pend_i,
  input logic           err_i
);
  // R10
  a_r10_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_ni));
  // R4
  a_r4_sck_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_ni) |-> sck_i);
  // R4
  a_r4_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_i && $past(sck_i)) |-> $stable(mosi_i));
  // R5
  a_r5_pend_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> !(&cs_ni));
  // R6
  a_r6_collision_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SEL_CMD && pend_i) |=> err_i);
  // R7
  a_r7_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SEL_STAT && reg_wdata_i[ST_ERR_BIT]) |=> !err_i);
endmodule

bind sfc_seq sfc_seq_chk #(.NCS(NCS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .cs_ni      (cs_no),
  .sck_i      (sck_o),
  .mosi_i     (mosi_o),
  .pend_i     (pend_q),
  .err_i      (err_q)
);

// File: tb/sim_sfc_seq.sv
module sim_sfc_seq;
  localparam int unsigned NCS = 8;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           we = 1'b0;
  logic [1:0]     sel = 2'd0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic           sck, mosi, miso;
  logic [NCS-1:0] cs_n;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sfc_seq #(.HALF_CYC(2), .NCS(NCS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  // flash model: records MOSI bytes, returns a counting pattern on MISO
  logic [7:0]     mon_b [0:63];
  logic [7:0]     mon_sh = '0;
  logic [NCS-1:0] mon_cs = '1;
  int             mon_bits = 0;
  logic [7:0]     exp_b [0:63];

  function automatic logic [7:0] pat_byte(input int k);
    return 8'(8'h5A + k * 8'h37);
  endfunction

  function automatic logic pat_bit(input int n);
    logic [7:0] b = pat_byte(n / 8);
    return b[7 - (n % 8)];
  endfunction

  assign miso = pat_bit(mon_bits);

  always @(posedge sck) begin
    if (!(&cs_n)) begin
      mon_sh = {mon_sh[6:0], mosi};
      mon_bits++;
      if (mon_bits % 8 == 0 && mon_bits / 8 <= 64) mon_b[mon_bits/8-1] = mon_sh;
      mon_cs = cs_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(2'd3, st);
      if (!st[22]) break;
    end
  endtask

  // expected wire bytes and data register, from the requirements
  task automatic build_exp(input logic [31:0] c, input logic [31:0] a, input logic [31:0] d,
                           input bit held, input int base, output int n, output logic [31:0] dexp);
    int al = (c[22:20] > 3'd4) ? 4 : int'(c[22:20]);
    int dl = (c[11:9] > 3'd4) ? 4 : int'(c[11:9]);
    int du = int'(c[19:16]);
    n = 0;
    dexp = d;
    if (!held) begin
      exp_b[n] = c[7:0]; n++;
      for (int i = 0; i < al; i++) begin exp_b[n] = a[8*(al-1-i) +: 8]; n++; end
      for (int i = 0; i < du; i++) begin exp_b[n] = 8'h00; n++; end
    end
    for (int j = 0; j < dl; j++) begin
      if (c[8]) exp_b[n] = d[8*j +: 8];
      else begin dexp[8*j +: 8] = pat_byte(base + n); exp_b[n] = 8'h00; end
      n++;
    end
  endtask

  task automatic run_cmd(input logic [31:0] c, input logic [31:0] a, input logic [31:0] d,
                         input bit held, input bit clr, input string tag);
    int base, n;
    logic [31:0] dexp, got;
    int bad;
    if (clr) mon_bits = 0;
    base = mon_bits / 8;
    reg_wr(2'd0, a);
    reg_wr(2'd1, d);
    reg_wr(2'd2, c);
    wait_idle();
    build_exp(c, a, d, held, base, n, dexp);
    chk(mon_bits == (base + n) * 8, tag, "wire bit count", mon_bits, (base + n) * 8);
    bad = -1;
    for (int i = 0; i < n; i++) if (bad < 0 && mon_b[base+i] !== exp_b[i]) bad = i;
    chk(bad < 0, tag, "wire byte", (bad < 0) ? 32'd0 : {24'd0, mon_b[base+bad]},
        (bad < 0) ? 32'd0 : {24'd0, exp_b[bad]});
    reg_rd(2'd1, got);
    chk(got === dexp, tag, "data register", got, dexp);
  endtask

  typedef struct packed {
    logic [31:0] c;
    logic [31:0] a;
    logic [31:0] d;
  } vec_t;

  // command, address, data preload
  localparam vec_t VECS [5] = '{
    '{32'h0130_0702, 32'h0012_3456, 32'h00CC_BBAA},  // write 3, addr 3, sel 1
    '{32'h0231_080B, 32'h00AB_CDEF, 32'h0000_0000},  // read 4, addr 3, dummy 1, sel 2
    '{32'h0000_0006, 32'h0000_0000, 32'h1111_1111},  // opcode only, sel 0
    '{32'h0770_0203, 32'h1122_3344, 32'hDEAD_BEEF},  // addr count 7 -> 4, read 1, sel 7
    '{32'h050F_0F32, 32'h0000_0000, 32'h4433_2211}   // dummy 15, write count 7 -> 4, sel 5
  };

  initial begin
    logic [31:0] r;
    repeat (200000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R11 reset state
    reg_rd(2'd3, r);
    chk(r === 32'd0, "R11", "status after reset", r, 32'd0);
    chk(cs_n === '1, "R11", "selects after reset", 32'(cs_n), 32'hFF);
    chk(sck === 1'b1, "R11", "sck after reset", 32'(sck), 32'd1);

    // R1 R2 R3 R10 vector walk
    foreach (VECS[k]) begin
      run_cmd(VECS[k].c, VECS[k].a, VECS[k].d, 1'b0, 1'b1, "R1 R2 R3");
      reg_rd(2'd2, r);
      chk(r === VECS[k].c, "R1", "command readback", r, VECS[k].c);
      chk(mon_cs === ~(NCS'(1) << VECS[k].c[26:24]), "R10", "select line used",
          32'(mon_cs), 32'(~(NCS'(1) << VECS[k].c[26:24])));
      chk(cs_n === '1 && sck === 1'b1, "R4 R10", "idle select and clock", {cs_n, 7'd0, sck}, {8'hFF, 8'h01});
    end

    // R8 R9 held chain
    run_cmd(32'h0231_880B, 32'h00AB_CDEF, 32'h0, 1'b0, 1'b1, "R8");
    chk(cs_n === 8'b1111_1011, "R8", "select held after keep", 32'(cs_n), 32'hFB);
    run_cmd(32'h0530_84FF, 32'h0000_0000, 32'h7777_7777, 1'b1, 1'b0, "R8");
    chk(cs_n === 8'b1111_1011, "R8", "held index kept", 32'(cs_n), 32'hFB);
    run_cmd(32'h0000_0000, 32'h0, 32'h0, 1'b1, 1'b0, "R9");
    chk(cs_n === '1, "R9", "select released", 32'(cs_n), 32'hFF);

    // R5 R6 R7 collision and error clear
    mon_bits = 0;
    reg_wr(2'd1, 32'hCAFE_0000);
    reg_wr(2'd2, 32'h0000_0006);
    reg_rd(2'd3, r);
    chk(r[22] === 1'b1, "R5", "pending during frame", r, 32'h0040_0000);
    reg_wr(2'd2, 32'h0000_009F);
    reg_wr(2'd1, 32'h1234_5678);
    wait_idle();
    reg_rd(2'd3, r);
    chk(r === 32'h2000_0000, "R6", "error set, pending clear", r, 32'h2000_0000);
    reg_rd(2'd2, r);
    chk(r === 32'h0000_0006, "R6", "second command ignored", r, 32'h6);
    reg_rd(2'd1, r);
    chk(r === 32'hCAFE_0000, "R6", "data write ignored while pending", r, 32'hCAFE_0000);
    chk(mon_bits == 8 && mon_b[0] === 8'h06, "R6", "only first frame on wire", mon_bits, 32'd8);
    reg_wr(2'd3, 32'h0040_0000);
    reg_rd(2'd3, r);
    chk(r === 32'h2000_0000, "R7", "error kept on other write", r, 32'h2000_0000);
    reg_wr(2'd3, 32'h2000_0000);
    reg_rd(2'd3, r);
    chk(r === 32'd0, "R7", "error cleared", r, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule